// File: doc/BRIEF.md
# Ternary ALU Slice on Binary-Coded Trits

A combinational arithmetic and logic slice that works on single three-valued digits (trits). Each trit travels on a 2-bit binary code. A one-bit mode input chooses between an arithmetic group and a logic group. Two select trits then pick the operation inside that group. The slice returns a result trit and a second trit that carries the carry, borrow or high product digit.

In arithmetic mode the slice performs a half add, a half subtract, a single-digit multiply and a three-way magnitude compare. In logic mode it offers nine functions. These are minimum, maximum, modulo-3 sum, and the minimum and the maximum each passed through one of three ternary inverters. The carry trit is placed beside the result so that wider units can chain slices. No state is held.

Top module: `tern_alu_slice`

## Requirements
- R1: Trit codes are 2'b00 = 0 (low), 2'b01 = 1 (middle) and 2'b10 = 2 (high). If x_i, y_i, sel_a_i or sel_b_i carries 2'b11, then res_o and cy_o are both 2'b11. Otherwise neither output is ever 2'b11, except as described in R6.
- R2: When mode_i=0 and select (sel_a_i, sel_b_i)=(0,0), res_o=(x+y) mod 3 and cy_o=1 if x+y≥3, else cy_o=0.
- R3: When mode_i=0 and select (0,1), res_o=(x−y) mod 3 and cy_o=1 if x<y, else cy_o=0.
- R4: When mode_i=0 and select (0,2), res_o=(x·y) mod 3 and cy_o=floor(x·y/3). For example, 2×2 gives res_o=1 and cy_o=1.
- R5: When mode_i=0 and select (1,0), res_o=0, 1 or 2 when x<y, x=y or x>y respectively, and cy_o=0.
- R6: When mode_i=0, the select pairs (1,1), (1,2), (2,0), (2,1) and (2,2) are unused. They drive both res_o and cy_o to 2'b11.
- R7: When mode_i=1, select (0,0) gives res_o=min(x,y) and select (0,1) gives res_o=max(x,y).
- R8: When mode_i=1 and select (0,2), res_o=(x+y) mod 3.
- R9: When mode_i=1, selects (1,0), (1,1) and (1,2) return min(x,y) passed through an inverter:
  - (1,0) uses the standard inverter, which maps v to 2−v.
  - (1,1) uses the positive inverter, which maps 0 and 1 to 2, and 2 to 0.
  - (1,2) uses the negative inverter, which maps 0 to 2, and 1 and 2 to 0.
- R10: When mode_i=1, selects (2,0), (2,1) and (2,2) return max(x,y) through the standard, positive and negative inverter, in that order.
- R11: In logic mode with legal inputs, cy_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 2 | First operand trit |
| y_i | input | 2 | Second operand trit |
| mode_i | input | 1 | 0 = arithmetic group, 1 = logic group |
| sel_a_i | input | 2 | Upper select trit |
| sel_b_i | input | 2 | Lower select trit |
| res_o | output | 2 | Result trit |
| cy_o | output | 2 | Carry, borrow or high-digit trit |

## Verification
Every legal combination of operands, mode and select is applied: 162 cases. This separates each operation from its neighbours. It also covers the wrap points of the sum, the difference and the product (2+2, 0−2, 2×2), and all three outcomes of the compare and of every inverter. Random patterns draw each 2-bit code uniformly, so the illegal code turns up on single inputs and on several inputs at once. These patterns show that the illegal code wins over any operation and that no legal input leaks it. The unused arithmetic selects are reached both by the sweep and by random draws.

// File: rtl/tern_alu_pkg.sv
package tern_alu_pkg;
    localparam int TRIT_W  = 2;
    localparam int N_LOGIC = 9;
    localparam int SEL_W   = $clog2(N_LOGIC);

    typedef logic [TRIT_W-1:0] trit_t;
    typedef logic [SEL_W-1:0]  sel_t;

    localparam trit_t T_LO  = 2'd0;
    localparam trit_t T_MID = 2'd1;
    localparam trit_t T_HI  = 2'd2;
    localparam trit_t T_BAD = 2'd3;

    typedef enum logic [1:0] {
        INV_STD = 2'd0,
        INV_POS = 2'd1,
        INV_NEG = 2'd2
    } inv_kind_e;

    typedef struct packed {
        trit_t res;
        trit_t cy;
    } slice_out_t;
endpackage

// File: rtl/trit_inv.sv
module trit_inv
    import tern_alu_pkg::*;
#(
    parameter inv_kind_e KIND = INV_STD
) (
    input  trit_t a_i,
    output trit_t y_o
);
    generate
        if (KIND == INV_STD) begin : g_std
            assign y_o = T_HI - a_i;
        end else if (KIND == INV_POS) begin : g_pos
            assign y_o = (a_i == T_HI) ? T_LO : T_HI;
        end else begin : g_neg
            assign y_o = (a_i == T_LO) ? T_HI : T_LO;
        end
    endgenerate
endmodule

// File: rtl/trit_logic_unit.sv
module trit_logic_unit
    import tern_alu_pkg::*;
(
    input  trit_t x_i,
    input  trit_t y_i,
    input  sel_t  sel_i,
    output trit_t res_o
);
    trit_t min_w;
    trit_t max_w;
    trit_t xor_w;
    trit_t [2:0] nand_w;
    trit_t [2:0] nor_w;
    logic [TRIT_W:0] sum_w;

    assign min_w = (x_i < y_i) ? x_i : y_i;
    assign max_w = (x_i < y_i) ? y_i : x_i;
    assign sum_w = {1'b0, x_i} + {1'b0, y_i};
    assign xor_w = (sum_w >= 3'd3) ? trit_t'(sum_w - 3'd3) : trit_t'(sum_w);

    for (genvar k = 0; k < 3; k++) begin : g_inv
        trit_inv #(.KIND(inv_kind_e'(k))) u_nand (.a_i(min_w), .y_o(nand_w[k]));
        trit_inv #(.KIND(inv_kind_e'(k))) u_nor  (.a_i(max_w), .y_o(nor_w[k]));
    end

    always_comb begin
        case (sel_i)
            4'd0:    res_o = min_w;
            4'd1:    res_o = max_w;
            4'd2:    res_o = xor_w;
            4'd3:    res_o = nand_w[0];
            4'd4:    res_o = nand_w[1];
            4'd5:    res_o = nand_w[2];
            4'd6:    res_o = nor_w[0];
            4'd7:    res_o = nor_w[1];
            4'd8:    res_o = nor_w[2];
            default: res_o = T_BAD;
        endcase
    end
endmodule

// File: rtl/trit_arith_unit.sv
module trit_arith_unit
    import tern_alu_pkg::*;
(
    input  trit_t      x_i,
    input  trit_t      y_i,
    input  sel_t       sel_i,
    output slice_out_t out_o
);
    logic [TRIT_W:0]     sum_w;
    logic [2*TRIT_W-1:0] prod_w;
    slice_out_t add_w, sub_w, mul_w, cmp_w;

    assign sum_w  = {1'b0, x_i} + {1'b0, y_i};
    assign prod_w = {2'b00, x_i} * {2'b00, y_i};

    always_comb begin
        add_w.res = (sum_w >= 3'd3) ? trit_t'(sum_w - 3'd3) : trit_t'(sum_w);
        add_w.cy  = (sum_w >= 3'd3) ? T_MID : T_LO;

        sub_w.res = (x_i >= y_i) ? trit_t'(x_i - y_i) : trit_t'(x_i + 2'd3 - y_i);
        sub_w.cy  = (x_i < y_i) ? T_MID : T_LO;

        mul_w.res = (prod_w >= 4'd3) ? trit_t'(prod_w - 4'd3) : trit_t'(prod_w);
        mul_w.cy  = (prod_w >= 4'd3) ? T_MID : T_LO;

        cmp_w.res = (x_i < y_i) ? T_LO : ((x_i == y_i) ? T_MID : T_HI);
        cmp_w.cy  = T_LO;

        case (sel_i)
            4'd0:    out_o = add_w;
            4'd1:    out_o = sub_w;
            4'd2:    out_o = mul_w;
            4'd3:    out_o = cmp_w;
            default: out_o = '{res: T_BAD, cy: T_BAD};
        endcase
    end
endmodule

// File: rtl/tern_alu_slice.sv
module tern_alu_slice
    import tern_alu_pkg::*;
(
    input  logic [1:0] x_i,
    input  logic [1:0] y_i,
    input  logic       mode_i,
    input  logic [1:0] sel_a_i,
    input  logic [1:0] sel_b_i,
    output logic [1:0] res_o,
    output logic [1:0] cy_o
);
    sel_t       sel_idx;
    logic       any_bad;
    trit_t      logic_res;
    slice_out_t arith_out;
    slice_out_t slice_d;

    assign sel_idx = sel_t'({2'b00, sel_a_i} * 4'd3 + {2'b00, sel_b_i});
    assign any_bad = (x_i == T_BAD) | (y_i == T_BAD) |
                     (sel_a_i == T_BAD) | (sel_b_i == T_BAD);

    trit_logic_unit u_logic (
        .x_i   (x_i),
        .y_i   (y_i),
        .sel_i (sel_idx),
        .res_o (logic_res)
    );

    trit_arith_unit u_arith (
        .x_i   (x_i),
        .y_i   (y_i),
        .sel_i (sel_idx),
        .out_o (arith_out)
    );

    always_comb begin
        if (any_bad) begin
            slice_d = '{res: T_BAD, cy: T_BAD};
        end else if (mode_i) begin
            slice_d = '{res: logic_res, cy: T_LO};
        end else begin
            slice_d = arith_out;
        end
    end

    assign res_o = slice_d.res;
    assign cy_o  = slice_d.cy;
endmodule

// File: rtl/tern_alu_slice_chk.sv
module tern_alu_slice_chk (
    input logic [1:0] x_i,
    input logic [1:0] y_i,
    input logic       mode_i,
    input logic [1:0] sel_a_i,
    input logic [1:0] sel_b_i,
    input logic [1:0] res_o,
    input logic [1:0] cy_o
);
    int  xv, yv, rv, cv;
    logic bad, unused;

    always_comb begin
        xv     = int'(x_i);
        yv     = int'(y_i);
        rv     = int'(res_o);
        cv     = int'(cy_o);
        bad    = (x_i == 2'b11) || (y_i == 2'b11) || (sel_a_i == 2'b11) || (sel_b_i == 2'b11);
        unused = !mode_i && (sel_a_i == 2'd2 || (sel_a_i == 2'd1 && sel_b_i != 2'd0));

        if (bad) begin
            assert_illegal_in_R1: assert (res_o == 2'b11 && cy_o == 2'b11);
        end else if (unused) begin
            assert_unused_sel_R6: assert (res_o == 2'b11 && cy_o == 2'b11);
        end else begin
            assert_legal_out_R1: assert (res_o != 2'b11 && cy_o != 2'b11);
            if (!mode_i && sel_a_i == 2'd0 && sel_b_i == 2'd0) begin
                assert_add_R2: assert (rv + 3 * cv == xv + yv);
            end
            if (!mode_i && sel_a_i == 2'd0 && sel_b_i == 2'd1) begin
                assert_sub_R3: assert (xv + 3 * cv == yv + rv && cv <= 1);
            end
            if (!mode_i && sel_a_i == 2'd0 && sel_b_i == 2'd2) begin
                assert_mul_R4: assert (rv + 3 * cv == xv * yv);
            end
            if (!mode_i && sel_a_i == 2'd1) begin
                assert_cmp_carry_R5: assert (cv == 0);
            end
            if (mode_i) begin
                assert_logic_carry_R11: assert (cv == 0);
            end
            if (mode_i && sel_a_i == 2'd0 && sel_b_i == 2'd0) begin
                assert_tand_R7: assert (rv <= xv && rv <= yv && (rv == xv || rv == yv));
            end
            if (mode_i && sel_a_i == 2'd0 && sel_b_i == 2'd1) begin
                assert_tor_R7: assert (rv >= xv && rv >= yv && (rv == xv || rv == yv));
            end
        end
    end
endmodule

bind tern_alu_slice tern_alu_slice_chk u_chk (
    .x_i     (x_i),
    .y_i     (y_i),
    .mode_i  (mode_i),
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .res_o   (res_o),
    .cy_o    (cy_o)
);

// File: tb/sim_tern_alu_slice.sv
`timescale 1ns/1ps
module sim_tern_alu_slice;
    logic       clk = 1'b0;
    logic [1:0] x, y, sa, sb;
    logic       md;
    logic [1:0] res, cy;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tern_alu_slice u0 (
        .x_i(x), .y_i(y), .mode_i(md), .sel_a_i(sa), .sel_b_i(sb),
        .res_o(res), .cy_o(cy)
    );

    function automatic int inv_std(int v); return 2 - v; endfunction
    function automatic int inv_pos(int v); return (v == 2) ? 0 : 2; endfunction
    function automatic int inv_neg(int v); return (v == 0) ? 2 : 0; endfunction

    // Expected {res, cy} as a 4-bit value, from the requirements.
    function automatic logic [3:0] model(bit m, int xv, int yv, int av, int bv);
        int r, c, mn, mx, s;
        if (xv == 3 || yv == 3 || av == 3 || bv == 3) return 4'b1111; // R1
        mn = (xv < yv) ? xv : yv;
        mx = (xv > yv) ? xv : yv;
        s  = av * 3 + bv;
        c  = 0;
        r  = 0;
        if (!m) begin
            case (s)
                0: begin r = (xv + yv) % 3; c = (xv + yv) / 3; end
                1: begin r = (xv - yv + 3) % 3; c = (xv < yv) ? 1 : 0; end
                2: begin r = (xv * yv) % 3; c = (xv * yv) / 3; end
                3: begin r = (xv < yv) ? 0 : ((xv == yv) ? 1 : 2); end
                default: return 4'b1111; // R6
            endcase
        end else begin
            case (s)
                0: r = mn;
                1: r = mx;
                2: r = (xv + yv) % 3;
                3: r = inv_std(mn);
                4: r = inv_pos(mn);
                5: r = inv_neg(mn);
                6: r = inv_std(mx);
                7: r = inv_pos(mx);
                default: r = inv_neg(mx);
            endcase
        end
        return {r[1:0], c[1:0]};
    endfunction

    function automatic string req_of(bit m, int xv, int yv, int av, int bv);
        int s = av * 3 + bv;
        if (xv == 3 || yv == 3 || av == 3 || bv == 3) return "R1";
        if (!m) begin
            case (s)
                0: return "R2";
                1: return "R3";
                2: return "R4";
                3: return "R5";
                default: return "R6";
            endcase
        end
        if (s < 2) return "R7";
        if (s == 2) return "R8";
        if (s < 6) return "R9";
        return "R10";
    endfunction

    task automatic apply_check(bit m, logic [1:0] xv, logic [1:0] yv,
                               logic [1:0] av, logic [1:0] bv);
        logic [3:0] exp;
        @(negedge clk);
        md = m; x = xv; y = yv; sa = av; sb = bv;
        @(posedge clk);
        #2;
        exp = model(m, int'(xv), int'(yv), int'(av), int'(bv));
        checks++;
        if ({res, cy} !== exp) begin
            fails++;
            $display("FAIL %s m=%0d x=%0d y=%0d a=%0d b=%0d actual res=%0d cy=%0d expected res=%0d cy=%0d",
                     req_of(m, int'(xv), int'(yv), int'(av), int'(bv)), m, xv, yv, av, bv,
                     res, cy, exp[3:2], exp[1:0]);
        end
        // Logic-mode carry stays low on legal inputs (R11)
        if (m && exp != 4'b1111) begin
            checks++;
            if (cy !== 2'd0) begin
                fails++;
                $display("FAIL R11 actual cy=%0d expected 0", cy);
            end
        end
    endtask

    initial begin
        int seed_dummy;
        md = 1'b0; x = 2'd0; y = 2'd0; sa = 2'd0; sb = 2'd0;
        // Idle inputs all zero: addition of 0+0 (R2)
        apply_check(1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        // Directed corners
        apply_check(1'b0, 2'd2, 2'd2, 2'd0, 2'd0); // R2 wrap
        apply_check(1'b0, 2'd0, 2'd2, 2'd0, 2'd1); // R3 borrow
        apply_check(1'b0, 2'd2, 2'd2, 2'd0, 2'd2); // R4 2x2
        apply_check(1'b0, 2'd1, 2'd1, 2'd1, 2'd0); // R5 equal
        apply_check(1'b0, 2'd1, 2'd2, 2'd2, 2'd2); // R6 unused
        apply_check(1'b1, 2'd3, 2'd1, 2'd0, 2'd0); // R1 illegal operand
        apply_check(1'b1, 2'd1, 2'd1, 2'd3, 2'd0); // R1 illegal select
        // Exhaustive sweep over legal codes
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 3; a++)
                for (int b = 0; b < 3; b++)
                    for (int i = 0; i < 3; i++)
                        for (int j = 0; j < 3; j++)
                            apply_check(m[0], i[1:0], j[1:0], a[1:0], b[1:0]);
        // Random patterns, illegal codes included
        seed_dummy = $urandom(32'd20240611);
        for (int n = 0; n < 400; n++) begin
            logic [8:0] r;
            r = 9'($urandom);
            apply_check(r[8], r[7:6], r[5:4], r[3:2], r[1:0]);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule